// File: doc/BRIEF.md
# Packed Double-Precision Maximum Unit

This block takes two 128-bit operands, each carrying two IEEE-754 binary64 lanes, and returns a per-lane maximum. The selection rules are deliberately lopsided. When the comparison is undecided or special, the second operand wins: a pair of zeros, a NaN in either input, and equal values all return the second operand bit for bit. A signaling NaN that is returned keeps its quiet bit clear.

Alongside the packed result the unit reports two status flags, ORed over both lanes. The invalid flag marks a NaN input of any kind. The denormal flag marks a subnormal input. When the second operand was fetched from memory at an address that is not 16-byte aligned, the unit returns an alignment fault and no result.

Operands are accepted with a valid/ready handshake. The result sits in a single output register and stays there until the consumer takes it.

Top module: `fpmax_unit`

## Requirements
- R1: Lane k of the result (bits 64k+63:64k, k = 0 and 1) depends only on lane k of the first operand and lane k of the second operand.
- R2: If both lane inputs are zero (exponent and mantissa fields all zero), the lane result is the second operand's lane, including its sign bit, whatever the sign of either input.
- R3: If either lane input is a NaN (exponent all ones, mantissa nonzero), the lane result is the second operand's lane unchanged. A signaling NaN, whose mantissa bit 51 is clear, is returned with bit 51 still clear.
- R4: In every other case, the lane result is the first operand if it is strictly greater than the second, and the second operand otherwise, including on equality. Subnormal values and infinities are ordered at full precision.
- R5: out_invalid is 1 when any of the four lane inputs is a NaN, quiet or signaling.
- R6: out_denorm is 1 when any of the four lane inputs is subnormal (exponent zero, mantissa nonzero). A subnormal input never changes which value is selected.
- R7: When src_mem is 1 and src_addr[3:0] is not zero, the result has out_misalign = 1, out_data all zeros, and out_invalid and out_denorm both 0. When src_mem is 0, src_addr has no effect.
- R8: A result appears on the outputs with out_valid = 1 one cycle after the input is accepted (in_valid and in_ready both high at a rising edge). While out_ready is low, out_valid and all result outputs hold their values.
- R9: After reset, out_valid is 0 and in_ready is 1. While a result is pending, in_ready is 0 and an offered input is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can accept an operand pair |
| op_a | input | 128 | First operand, two binary64 lanes |
| op_b | input | 128 | Second operand, two binary64 lanes |
| src_mem | input | 1 | Second operand was read from memory |
| src_addr | input | 64 | Byte address of the second operand when src_mem is 1 |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the pending result |
| out_data | output | 128 | Packed maximum |
| out_invalid | output | 1 | NaN input seen in either lane |
| out_denorm | output | 1 | Subnormal input seen in either lane |
| out_misalign | output | 1 | Alignment fault; no result written |

## Verification
The hardest case to reach from the ports is an input offered while a result is still waiting. A consumer that is always ready never creates it. The stimulus therefore holds out_ready low, lets one result land, and then drives a different operand pair with in_valid high for several cycles. Only the original result must come out once out_ready rises. The operand patterns also pair the special encodings against each other in opposite orders, such as a signaling NaN against a number, zeros of opposite sign, and subnormals against subnormals, so that any symmetric shortcut in the selection shows up.

// File: rtl/fpmax_pkg.sv
package fpmax_pkg;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int LANE_W = 1 + EXP_W + MAN_W;

    typedef struct packed {
        logic              is_nan;
        logic              is_zero;
        logic              is_sub;
        logic              sign;
        logic [LANE_W-2:0] mag;
    } lane_cls_t;
endpackage

// File: rtl/fpmax_classify.sv
module fpmax_classify
    import fpmax_pkg::*;
(
    input  logic [LANE_W-1:0] val,
    output lane_cls_t         cls
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        exp_f       = val[LANE_W-2 -: EXP_W];
        man_f       = val[MAN_W-1:0];
        cls.sign    = val[LANE_W-1];
        cls.mag     = val[LANE_W-2:0];
        cls.is_nan  = (&exp_f) && (|man_f);
        cls.is_zero = (exp_f == '0) && (man_f == '0);
        cls.is_sub  = (exp_f == '0) && (|man_f);
    end
endmodule

// File: rtl/fpmax_pick.sv
module fpmax_pick
    import fpmax_pkg::*;
(
    input  logic [LANE_W-1:0] a_val,
    input  logic [LANE_W-1:0] b_val,
    input  lane_cls_t         a_cls,
    input  lane_cls_t         b_cls,
    output logic [LANE_W-1:0] res,
    output logic              nan_seen,
    output logic              sub_seen
);
    logic a_gt_b;

    always_comb begin
        // sign-magnitude ordering; undecided cases fall to the second operand
        if (a_cls.sign != b_cls.sign)
            a_gt_b = !a_cls.sign;
        else if (!a_cls.sign)
            a_gt_b = a_cls.mag > b_cls.mag;
        else
            a_gt_b = a_cls.mag < b_cls.mag;

        if (a_cls.is_zero && b_cls.is_zero)
            res = b_val;
        else if (a_cls.is_nan || b_cls.is_nan)
            res = b_val;
        else if (a_gt_b)
            res = a_val;
        else
            res = b_val;

        nan_seen = a_cls.is_nan || b_cls.is_nan;
        sub_seen = a_cls.is_sub || b_cls.is_sub;
    end
endmodule

// File: rtl/fpmax_unit.sv
module fpmax_unit
    import fpmax_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int ADDR_W      = 64,
    parameter int ALIGN_BYTES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANES*LANE_W-1:0]  op_a,
    input  logic [LANES*LANE_W-1:0]  op_b,
    input  logic                     src_mem,
    input  logic [ADDR_W-1:0]        src_addr,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANES*LANE_W-1:0]  out_data,
    output logic                     out_invalid,
    output logic                     out_denorm,
    output logic                     out_misalign
);
    localparam int DATA_W    = LANES * LANE_W;
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              inv;
        logic              den;
        logic              mis;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [DATA_W-1:0] lane_res;
    logic [LANES-1:0]  lane_nan;
    logic [LANES-1:0]  lane_sub;
    logic              fault;
    logic              take;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_cls_t cls_a, cls_b;

        fpmax_classify u_cls_a (
            .val (op_a[k*LANE_W +: LANE_W]),
            .cls (cls_a)
        );

        fpmax_classify u_cls_b (
            .val (op_b[k*LANE_W +: LANE_W]),
            .cls (cls_b)
        );

        fpmax_pick u_pick (
            .a_val    (op_a[k*LANE_W +: LANE_W]),
            .b_val    (op_b[k*LANE_W +: LANE_W]),
            .a_cls    (cls_a),
            .b_cls    (cls_b),
            .res      (lane_res[k*LANE_W +: LANE_W]),
            .nan_seen (lane_nan[k]),
            .sub_seen (lane_sub[k])
        );
    end

    always_comb begin
        fault = src_mem && (|src_addr[ALIGN_LSB-1:0]);
        take  = in_valid && !st_q.vld;
        st_d  = st_q;
        if (st_q.vld && out_ready)
            st_d.vld = 1'b0;
        if (take) begin
            st_d.vld  = 1'b1;
            st_d.mis  = fault;
            st_d.data = fault ? '0 : lane_res;
            st_d.inv  = !fault && (|lane_nan);
            st_d.den  = !fault && (|lane_sub);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign in_ready     = !st_q.vld;
    assign out_valid    = st_q.vld;
    assign out_data     = st_q.data;
    assign out_invalid  = st_q.inv;
    assign out_denorm   = st_q.den;
    assign out_misalign = st_q.mis;
endmodule

// File: rtl/fpmax_unit_chk.sv
module fpmax_unit_chk
    import fpmax_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              src_mem,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_invalid,
    input logic              out_denorm,
    input logic              out_misalign
);
    logic a_lane0_nan;
    assign a_lane0_nan = (&op_a[LANE_W-2 -: EXP_W]) && (|op_a[MAN_W-1:0]);

    // R8: one-cycle latency from acceptance
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R8: result held under backpressure
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_invalid) && $stable(out_denorm) && $stable(out_misalign));

    // R9: no acceptance while a result is pending
    a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R7: a fault carries no data and no status
    a_r7_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_misalign |-> out_data == '0 && !out_invalid && !out_denorm);

    // R3: NaN in first operand lane 0 returns second operand lane 0
    a_r3_nan_to_b: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !src_mem && a_lane0_nan
            |=> out_data[LANE_W-1:0] == $past(op_b[LANE_W-1:0]) && out_invalid);
endmodule

bind fpmax_unit fpmax_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .op_a         (op_a),
    .op_b         (op_b),
    .src_mem      (src_mem),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_invalid  (out_invalid),
    .out_denorm   (out_denorm),
    .out_misalign (out_misalign)
);

// File: tb/fpmax_unit_test.sv
`timescale 1ns/1ps
module fpmax_unit_test;
    localparam logic [63:0] P1   = 64'h3FF0000000000000;
    localparam logic [63:0] P2   = 64'h4000000000000000;
    localparam logic [63:0] N1   = 64'hBFF0000000000000;
    localparam logic [63:0] N2   = 64'hC000000000000000;
    localparam logic [63:0] PZ   = 64'h0000000000000000;
    localparam logic [63:0] NZ   = 64'h8000000000000000;
    localparam logic [63:0] QN   = 64'h7FF8000000000000;
    localparam logic [63:0] SN   = 64'h7FF0000000000001;
    localparam logic [63:0] SB1  = 64'h0000000000000001;
    localparam logic [63:0] SB2  = 64'h0000000000000002;
    localparam logic [63:0] NSB  = 64'h8000000000000001;
    localparam logic [63:0] PINF = 64'h7FF0000000000000;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;

    typedef struct {
        logic [127:0] data;
        logic         inv;
        logic         den;
        logic         mis;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic         src_mem = 1'b0;
    logic [63:0]  src_addr = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic         out_invalid;
    logic         out_denorm;
    logic         out_misalign;

    int checks = 0;
    int errors = 0;
    int outputs = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    fpmax_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .src_mem(src_mem), .src_addr(src_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_invalid(out_invalid), .out_denorm(out_denorm), .out_misalign(out_misalign)
    );

    function automatic logic is_nan(logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction
    function automatic logic is_zero(logic [63:0] v);
        return v[62:0] == 0;
    endfunction
    function automatic logic is_sub(logic [63:0] v);
        return (v[62:52] == 0) && (v[51:0] != 0);
    endfunction

    function automatic logic [63:0] model_lane(logic [63:0] a, logic [63:0] b);
        if (is_zero(a) && is_zero(b)) return b;
        if (is_nan(a) || is_nan(b)) return b;
        if ($bitstoreal(a) > $bitstoreal(b)) return a;
        return b;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic send(input string tag, input logic [63:0] a1, input logic [63:0] a0,
                        input logic [63:0] b1, input logic [63:0] b0,
                        input logic mem, input logic [63:0] addr);
        exp_t e;
        logic fault;
        fault = mem && (addr[3:0] != 0);
        e.tag  = tag;
        e.mis  = fault;
        e.data = fault ? '0 : {model_lane(a1, b1), model_lane(a0, b0)};
        e.inv  = !fault && (is_nan(a1) || is_nan(a0) || is_nan(b1) || is_nan(b0));
        e.den  = !fault && (is_sub(a1) || is_sub(a0) || is_sub(b1) || is_sub(b0));
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        sb.push_back(e);
        op_a = {a1, a0};
        op_b = {b1, b0};
        src_mem = mem;
        src_addr = addr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        // R8: result one cycle after acceptance
        check("R8 latency", {127'd0, out_valid}, 128'd1);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            outputs++;
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9: actual unexpected result expected none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " data"}, out_data, e.data);
                check({e.tag, " flags"}, {125'd0, out_invalid, out_denorm, out_misalign},
                      {125'd0, e.inv, e.den, e.mis});
            end
        end
    end

    initial begin : watchdog
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 reset", {126'd0, out_valid, in_ready}, 128'd1);

        // R4 ordinary ordering, R1 lanes independent
        send("R4 pos", P1, P2, P2, P1, 1'b0, 64'h0);
        send("R4 neg", N1, N2, N2, N1, 1'b0, 64'h0);
        send("R4 mixed", N1, P1, P2, N2, 1'b0, 64'h0);
        send("R4 equal", P1, N1, P1, N1, 1'b0, 64'h0);
        send("R4 inf", PINF, NINF, P2, N2, 1'b0, 64'h0);
        send("R4 zero vs nonzero", PZ, NZ, N1, N1, 1'b0, 64'h0);
        send("R1 lanes", P2, N2, N1, P1, 1'b0, 64'h0);
        // R2 zeros
        send("R2 zeros", PZ, NZ, NZ, PZ, 1'b0, 64'h0);
        send("R2 zeros same", NZ, PZ, NZ, PZ, 1'b0, 64'h0);
        // R3 NaNs, R5 invalid
        send("R3 snan in a", SN, QN, P1, N1, 1'b0, 64'h0);
        send("R3 snan in b", P2, P1, SN, QN, 1'b0, 64'h0);
        send("R5 nan one lane", P1, QN, P2, P1, 1'b0, 64'h0);
        send("R5 no nan", P1, P1, P2, P2, 1'b0, 64'h0);
        // R6 subnormals
        send("R6 sub order", SB1, NSB, SB2, SB1, 1'b0, 64'h0);
        send("R6 sub vs zero", SB2, PZ, PZ, NSB, 1'b0, 64'h0);
        // R7 alignment
        send("R7 misaligned", P2, P2, P1, P1, 1'b1, 64'h1008);
        send("R7 aligned mem", P2, N1, P1, N2, 1'b1, 64'h1020);
        send("R7 reg ignores addr", P2, QN, P1, SB1, 1'b0, 64'h0007);

        // R8 and R9 under backpressure
        @(negedge clk);
        out_ready = 1'b0;
        send("R8 held", N2, P2, N1, P1, 1'b0, 64'h0);
        held = out_data;
        op_a = {PINF, PINF};
        op_b = {NINF, NINF};
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 not ready", {126'd0, out_valid, in_ready}, 128'd2);
        check("R8 stable", out_data, held);
        in_valid = 1'b0;
        @(negedge clk);
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 no extra result", {96'd0, 32'(sb.size())}, 128'd0);
        check("R9 output count", {96'd0, 32'(outputs)}, 128'd19);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule